// File: doc/BRIEF.md
# Two-Byte-Per-Clock Pattern Automaton

This block runs a deterministic finite automaton over a byte stream and advances it by two bytes on every accepted beat. Each byte of the 16-bit beat is first folded into a 3-bit class code through a byte-to-class map. The two codes together form a 6-bit pair symbol. The pair symbol and the current state select the next state from a stride-two transition memory.

A match can end on either byte of a pair. Each state therefore carries two accept flags: one says the first byte of the pair that led here closed a match, the other says the second byte did. States that differ only in these flags are duplicates with identical outgoing transitions, so a match that ends in the middle of a stride is not lost. An odd-length tail is sent as a beat with only the low byte valid. The upper byte's class is then replaced by a reserved pad class, and only the first-position flag can fire.

All three tables are filled through one write port, and the tables are built off-chip. Results appear one clock after the beat as a per-lane match vector.

Top module: `dfa2_matcher`

## Requirements
- R1: While `rst_ni` is low and after its release, the state is 0, `match_o` and `match_lane_o` are 0, every byte maps to class 0, every next-state entry is 0 and every accept entry is 0.
- R2: A load with `ld_tgt_i`=0 stores class `ld_data_i[2:0]` for byte `ld_addr_i[7:0]`. Every later beat uses that class for that byte in either lane.
- R3: On a beat, the pair symbol is {class of `beat_data_i[7:0]`, class of `beat_data_i[15:8]`}, with the low byte taken as the first byte. The next state is the entry at address {state, pair} (state in bits 9:6), loaded with `ld_tgt_i`=1.
- R4: The accept entry of a state is loaded with `ld_tgt_i`=2, address = state and data bits 1:0. One clock after a beat, `match_lane_o[0]` equals bit 0 and `match_lane_o[1]` equals bit 1 of the accept entry of the new state. `match_o` is their OR.
- R5: A beat with `beat_single_i` high uses class 7 (pad) for the upper byte regardless of its value and never raises `match_lane_o[1]`.
- R6: In a cycle without `beat_valid_i`, the state holds and the match outputs are 0 in the next cycle, whatever `beat_data_i` carries.
- R7: A class-map load whose data is the pad class 7 is dropped, and the byte keeps its previous class.
- R8: A table load does not move the state. It affects any beat presented in a later cycle.
- R9: Both lanes may report a match from the same beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| beat_valid_i | input | 1 | Beat present this cycle |
| beat_data_i | input | 16 | Two bytes; bits 7:0 come first in the stream |
| beat_single_i | input | 1 | Only bits 7:0 of the beat are valid |
| ld_we_i | input | 1 | Table write strobe |
| ld_tgt_i | input | 2 | 0 class map, 1 next state, 2 accept flags, 3 none |
| ld_addr_i | input | 10 | Byte, {state,pair} or state, by target |
| ld_data_i | input | 4 | Class, next state or accept flags, by target |
| match_o | output | 1 | A match ended within the previous beat |
| match_lane_o | output | 2 | Bit i: the match ended on byte lane i |

## Verification
The hardest case to reach is a pad-padded odd tail that lands in a state whose second-position accept flag would be set if the pad were not applied. Reaching it needs a loaded automaton, a prefix that leaves the state one byte away from a match, and a single-byte beat whose ignored upper byte would itself complete a second match. The stimulus loads a two-pattern automaton ("ab" and "bb", case-folded through the class map). It then walks a vector table that reaches that state and sends a single beat carrying "bb". The same automaton also drives beats where both lanes match at once and beats where only the first lane matches.

// File: rtl/dfa2_pkg.sv
package dfa2_pkg;
  typedef enum logic [1:0] {
    LD_CLASS  = 2'd0,
    LD_NEXT   = 2'd1,
    LD_ACCEPT = 2'd2,
    LD_NONE   = 2'd3
  } ld_tgt_e;

  localparam int LANES = 2;
endpackage

// File: rtl/dfa2_class_map.sv
module dfa2_class_map #(
  parameter int BYTE_W = 8,
  parameter int CLS_W  = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [BYTE_W-1:0]             wr_byte_i,
  input  logic [CLS_W-1:0]              wr_cls_i,
  input  logic [dfa2_pkg::LANES-1:0][BYTE_W-1:0] rd_byte_i,
  output logic [dfa2_pkg::LANES-1:0][CLS_W-1:0]  rd_cls_o
);
  localparam int                 DEPTH   = 1 << BYTE_W;
  localparam logic [CLS_W-1:0]   PAD_CLS = '1;

  logic [CLS_W-1:0] map_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) map_q[i] <= '0;
    end else if (wr_en_i && (wr_cls_i != PAD_CLS)) begin
      map_q[wr_byte_i] <= wr_cls_i;
    end
  end

  for (genvar l = 0; l < dfa2_pkg::LANES; l++) begin : g_lane
    assign rd_cls_o[l] = map_q[rd_byte_i[l]];
  end

  // R2
  cls_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_cls_i != PAD_CLS) |=> map_q[$past(wr_byte_i)] == $past(wr_cls_i));

  // R7
  cls_pad_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_cls_i == PAD_CLS) |=> map_q[$past(wr_byte_i)] == $past(map_q[wr_byte_i]));
endmodule

// File: rtl/dfa2_trans_table.sv
module dfa2_trans_table #(
  parameter int STATE_W = 4,
  parameter int CLS_W   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_next_en_i,
  input  logic                       wr_acc_en_i,
  input  logic [STATE_W+2*CLS_W-1:0] wr_addr_i,
  input  logic [STATE_W-1:0]         wr_data_i,
  input  logic [STATE_W-1:0]         rd_state_i,
  input  logic [2*CLS_W-1:0]         rd_pair_i,
  output logic [STATE_W-1:0]         next_state_o,
  output logic [1:0]                 next_acc_o
);
  localparam int IDX_W   = STATE_W + 2*CLS_W;
  localparam int N_DEPTH = 1 << IDX_W;
  localparam int S_DEPTH = 1 << STATE_W;

  logic [STATE_W-1:0] next_q [N_DEPTH];
  logic [1:0]         acc_q  [S_DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_DEPTH; i++) next_q[i] <= '0;
    end else if (wr_next_en_i) begin
      next_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < S_DEPTH; i++) acc_q[i] <= '0;
    end else if (wr_acc_en_i) begin
      acc_q[wr_addr_i[STATE_W-1:0]] <= wr_data_i[1:0];
    end
  end

  // accept flags belong to the destination state: duplicates carry mid-stride hits
  assign next_state_o = next_q[{rd_state_i, rd_pair_i}];
  assign next_acc_o   = acc_q[next_state_o];

  // R8
  trn_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_next_en_i |=> next_q[$past(wr_addr_i)] == $past(wr_data_i));

  // R4
  acc_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc_en_i |=> acc_q[$past(wr_addr_i[STATE_W-1:0])] == $past(wr_data_i[1:0]));
endmodule

// File: rtl/dfa2_step.sv
module dfa2_step #(
  parameter int STATE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               beat_valid_i,
  input  logic               beat_single_i,
  input  logic [STATE_W-1:0] next_state_i,
  input  logic [1:0]         next_acc_i,
  output logic [STATE_W-1:0] state_o,
  output logic               match_o,
  output logic [1:0]         match_lane_o
);
  logic [STATE_W-1:0] state_q;
  logic [1:0]         lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      lane_q  <= '0;
    end else begin
      if (beat_valid_i) state_q <= next_state_i;
      lane_q <= beat_valid_i ? {next_acc_i[1] & ~beat_single_i, next_acc_i[0]} : 2'b00;
    end
  end

  assign state_o      = state_q;
  assign match_lane_o = lane_q;
  assign match_o      = |lane_q;

  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_valid_i |=> match_lane_o == 2'b00);

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_valid_i |=> $stable(state_q));

  // R5
  single_lane1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && beat_single_i) |=> !match_lane_o[1]);
endmodule

// File: rtl/dfa2_matcher.sv
module dfa2_matcher #(
  parameter int STATE_W = 4,
  parameter int CLS_W   = 3,
  parameter int BYTE_W  = 8,
  localparam int BEAT_W = dfa2_pkg::LANES * BYTE_W,
  localparam int TIDX_W = STATE_W + 2*CLS_W,
  localparam int ADDR_W = (TIDX_W > BYTE_W) ? TIDX_W : BYTE_W,
  localparam int DATA_W = (STATE_W > CLS_W) ? STATE_W : CLS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_valid_i,
  input  logic [BEAT_W-1:0] beat_data_i,
  input  logic              beat_single_i,
  input  logic              ld_we_i,
  input  logic [1:0]        ld_tgt_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              match_o,
  output logic [1:0]        match_lane_o
);
  import dfa2_pkg::*;

  localparam logic [CLS_W-1:0] PAD_CLS = '1;

  ld_tgt_e tgt;
  logic [LANES-1:0][BYTE_W-1:0] lane_byte;
  logic [LANES-1:0][CLS_W-1:0]  lane_cls;
  logic [CLS_W-1:0]             cls_hi;
  logic [2*CLS_W-1:0]           pair;
  logic [STATE_W-1:0]           state, next_state;
  logic [1:0]                   next_acc;

  assign tgt = ld_tgt_e'(ld_tgt_i);

  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign lane_byte[l] = beat_data_i[l*BYTE_W +: BYTE_W];
  end

  dfa2_class_map #(.BYTE_W(BYTE_W), .CLS_W(CLS_W)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (ld_we_i && tgt == LD_CLASS),
    .wr_byte_i (ld_addr_i[BYTE_W-1:0]),
    .wr_cls_i  (ld_data_i[CLS_W-1:0]),
    .rd_byte_i (lane_byte),
    .rd_cls_o  (lane_cls)
  );

  // odd tail: upper byte replaced by the pad class
  assign cls_hi = beat_single_i ? PAD_CLS : lane_cls[1];
  assign pair   = {lane_cls[0], cls_hi};

  dfa2_trans_table #(.STATE_W(STATE_W), .CLS_W(CLS_W)) u_tbl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_next_en_i (ld_we_i && tgt == LD_NEXT),
    .wr_acc_en_i  (ld_we_i && tgt == LD_ACCEPT),
    .wr_addr_i    (ld_addr_i[TIDX_W-1:0]),
    .wr_data_i    (ld_data_i[STATE_W-1:0]),
    .rd_state_i   (state),
    .rd_pair_i    (pair),
    .next_state_o (next_state),
    .next_acc_o   (next_acc)
  );

  dfa2_step #(.STATE_W(STATE_W)) u_step (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .beat_valid_i  (beat_valid_i),
    .beat_single_i (beat_single_i),
    .next_state_i  (next_state),
    .next_acc_i    (next_acc),
    .state_o       (state),
    .match_o       (match_o),
    .match_lane_o  (match_lane_o)
  );

  // R8
  load_no_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_we_i && !beat_valid_i) |=> $stable(state));
endmodule

// File: tb/dfa2_matcher_test.sv
module dfa2_matcher_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        beat_valid_i = 1'b0;
  logic [15:0] beat_data_i = '0;
  logic        beat_single_i = 1'b0;
  logic        ld_we_i = 1'b0;
  logic [1:0]  ld_tgt_i = '0;
  logic [9:0]  ld_addr_i = '0;
  logic [3:0]  ld_data_i = '0;
  logic        match_o;
  logic [1:0]  match_lane_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dfa2_matcher uut (
    .clk_i(clk), .rst_ni(rst_ni), .beat_valid_i(beat_valid_i),
    .beat_data_i(beat_data_i), .beat_single_i(beat_single_i),
    .ld_we_i(ld_we_i), .ld_tgt_i(ld_tgt_i), .ld_addr_i(ld_addr_i),
    .ld_data_i(ld_data_i), .match_o(match_o), .match_lane_o(match_lane_o)
  );

  // {valid, single, hi byte, lo byte, expected lanes}; patterns "ab","bb", case folded
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h62, 8'h61, 2'b10},  // "ab"
    {1'b1, 1'b0, 8'h61, 8'h78, 2'b00},  // "xa"
    {1'b1, 1'b0, 8'h78, 8'h62, 2'b01},  // "bx"
    {1'b1, 1'b0, 8'h42, 8'h41, 2'b10},  // "AB"
    {1'b0, 1'b0, 8'h62, 8'h62, 2'b00},  // idle with data
    {1'b1, 1'b0, 8'h62, 8'h62, 2'b11},  // "bb" both lanes
    {1'b1, 1'b0, 8'h62, 8'h78, 2'b00},  // "xb"
    {1'b1, 1'b0, 8'h78, 8'h62, 2'b01},  // "bx"
    {1'b1, 1'b0, 8'h61, 8'h62, 2'b00},  // "ba"
    {1'b1, 1'b1, 8'h62, 8'h62, 2'b01},  // single "b", hi ignored
    {1'b1, 1'b0, 8'h62, 8'h61, 2'b10},  // "ab"
    {1'b1, 1'b1, 8'h62, 8'h78, 2'b00},  // single "x"
    {1'b1, 1'b0, 8'h42, 8'h62, 2'b10}   // "bB"
  };

  function automatic string vec_tag(input int i);
    case (i)
      4:       return "R6";
      5:       return "R9";
      9, 11:   return "R5";
      3, 12:   return "R2";
      default: return "R3/R4";
    endcase
  endfunction

  // single-byte automaton: 0 none, 1 after a, 2 match (after b), 3 lone b
  function automatic logic [1:0] step1(input logic [1:0] q, input logic [2:0] c);
    if (c == 3'd1) return 2'd1;
    if (c == 3'd2) return (q != 2'd0) ? 2'd2 : 2'd3;
    return 2'd0;
  endfunction

  task automatic check_out(input logic [1:0] exp, input string tag);
    checks++;
    if (match_lane_o !== exp || match_o !== (|exp)) begin
      failures++;
      $display("FAIL %s lanes=%b match=%b expected lanes=%b match=%b",
               tag, match_lane_o, match_o, exp, |exp);
    end
  endtask

  task automatic load(input logic [1:0] t, input logic [9:0] a, input logic [3:0] d);
    @(negedge clk);
    ld_we_i = 1'b1; ld_tgt_i = t; ld_addr_i = a; ld_data_i = d;
    @(posedge clk);
    #1 ld_we_i = 1'b0;
  endtask

  task automatic beat(input logic v, input logic s, input logic [15:0] d);
    @(negedge clk);
    beat_valid_i = v; beat_single_i = s; beat_data_i = d;
    @(posedge clk);
    #1 beat_valid_i = 1'b0; beat_single_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 during reset
    repeat (2) @(negedge clk);
    check_out(2'b00, "R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check_out(2'b00, "R1 after release");
    // R1 cleared tables: a would-be match gives nothing
    beat(1'b1, 1'b0, 16'h6262);
    check_out(2'b00, "R1 empty tables");

    // class map: a,A -> 1; b,B -> 2
    load(2'd0, 10'h061, 4'd1);
    load(2'd0, 10'h041, 4'd1);
    load(2'd0, 10'h062, 4'd2);
    load(2'd0, 10'h042, 4'd2);
    // transition and accept tables
    for (int s = 0; s < 16; s++) begin
      load(2'd2, 10'(s), {2'b00, s[3], s[2]});
      for (int p = 0; p < 64; p++) begin
        logic [2:0] c0, c1;
        logic [1:0] q1, q2;
        logic a0, a1;
        c0 = p[5:3]; c1 = p[2:0];
        q1 = step1(s[1:0], c0);
        a0 = (q1 == 2'd2);
        if (c1 == 3'd7) begin q2 = q1; a1 = 1'b0; end
        else begin q2 = step1(q1, c1); a1 = (q2 == 2'd2); end
        load(2'd1, {s[3:0], p[5:0]}, {a1, a0, q2});
      end
    end
    // R8 loads left the state at 0: "bx" from start is no match
    beat(1'b1, 1'b0, 16'h7862);
    check_out(2'b00, "R8 state unmoved by loads");

    for (int i = 0; i < NV; i++) begin
      beat(VEC[i][19], VEC[i][18], VEC[i][17:2]);
      check_out(VEC[i][1:0], $sformatf("%s vector %0d", vec_tag(i), i));
    end

    // R2: remap x (0x78) to class 1, "xb" now matches on lane 1
    load(2'd0, 10'h078, 4'd1);
    beat(1'b1, 1'b0, 16'h6278);
    check_out(2'b10, "R2 remapped byte");
    // R7: pad write for x dropped; x still class 1
    load(2'd0, 10'h078, 4'd7);
    beat(1'b1, 1'b0, 16'h6278);
    check_out(2'b10, "R7 pad class write ignored");

    // R8: clear accept of state 10 (q=2, lane1 flag) then "ab" lands there
    load(2'd2, 10'd10, 4'd0);
    beat(1'b1, 1'b0, 16'h6261);
    check_out(2'b00, "R8 accept write takes effect");
    load(2'd2, 10'd10, 4'b0010);
    beat(1'b1, 1'b0, 16'h6261);
    check_out(2'b10, "R4 accept restored");
    // R6: idle after a match drops outputs
    @(negedge clk);
    check_out(2'b00, "R6 idle cycle");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule